// File: doc/BRIEF.md
# Rate and Burst Float Encoder

This block turns an integer burst size in bytes and a target rate in bits per second into the short mantissa/exponent codes that a token-bucket policer consumes. Both codes have the value (1 + M/256) · 2^E, with an 8-bit mantissa M. The burst code gives the bucket depth in bytes. The rate code gives the number of tokens added once per refill period of 2 µs · 2^D, where D is a separate time-divider field.

A caller loads both values with a one-cycle start strobe. The block then works through iterative shifts, compares and a restoring division. No floating point and no divider macro are used. When the codes are ready it raises a single-cycle done pulse. The five result fields change only at that pulse and then hold until the next result is published. A start strobe that arrives while a conversion is in flight is dropped.

The rate path first scales the input to floor(rate / 4). This equals bytes per 2 µs times 10^6, which keeps integer precision up to well past 100 Gbps. It then normalises that value into the window [256·10^6, 512·10^6). Below the window it doubles the value and counts doublings into D. At or above the window it halves the value and counts halvings into E.

Top module: `rate_burst_encoder`

## Requirements
- R1: For 1 ≤ burst < 2^23, the burst exponent equals floor(log2(burst)).
- R2: For a burst exponent e ≥ 8 (no clamp), the burst mantissa is floor((burst − 2^e) / 2^(e−8)). For e < 8 it is 0.
- R3: For burst ≥ 2^23, the burst exponent clamps to 22 and the burst mantissa to 255.
- R4: The rate path works on s = floor(rate / 4). An s of 0 gives rate exponent, mantissa and divider all 0.
- R5: While s < 256·10^6, s is doubled and each doubling adds one to the rate divider. In that case the rate exponent is 0.
- R6: While s ≥ 512·10^6 and the exponent is below 22, s is halved and each halving adds one to the rate exponent. In that case the divider is 0.
- R7: When s ends inside the window, the rate mantissa is floor((s − 256·10^6) / 10^6).
- R8: If s is still ≥ 512·10^6 after 22 halvings, the rate exponent is 22, the mantissa 255 and the divider 0.
- R9: A burst of 0 gives burst exponent 0 and mantissa 0, and done_o still pulses.
- R10: done_o is high for exactly one cycle, no more than 48 cycles after the clock edge that accepts start_i.
- R11: start_i is ignored from the edge that accepts a start until done_o has been raised. The published result reflects the accepted inputs.
- R12: All five result outputs change only at the edge that raises done_o. After reset they are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| burst_i | input | BURST_W (32) | Burst size in bytes |
| rate_i | input | RATE_W (56) | Rate in bits per second |
| burst_exp_o | output | 5 | Burst exponent |
| burst_man_o | output | 8 | Burst mantissa |
| rate_exp_o | output | 5 | Rate exponent |
| rate_man_o | output | 8 | Rate mantissa |
| rate_div_o | output | 5 | Refill-period divider exponent |
| done_o | output | 1 | One-cycle result-ready pulse |

## Verification
The restoring-divider bound assumes that the dividend handed to it is below 256·10^6. The top guarantees this only because the normaliser leaves the scaled rate under the window top whenever it is not saturated. The window assertions check that premise directly. The latency bound assumes that a nonzero scaled rate needs at most 28 doublings, which holds for any value of at least 1. The stimulus spans zero, sub-window, in-window, above-window and saturating rates, and both clamped and small bursts, so every normaliser branch and the divider are driven within these premises.

// File: rtl/rbenc_pkg.sv
package rbenc_pkg;
  localparam int unsigned WIN_LO    = 256_000_000;
  localparam int unsigned WIN_HI    = 512_000_000;
  localparam int unsigned MANT_STEP = 1_000_000;
  localparam int unsigned EXP_CAP   = 22;
  localparam int unsigned MANT_W    = 8;
  localparam int unsigned EXP_W     = 5;
  localparam int unsigned RDIV_W    = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_DIV} enc_state_e;
endpackage

// File: rtl/burst_enc.sv
module burst_enc #(
  parameter int BW   = 32,
  parameter int EW   = 5,
  parameter int MW   = 8,
  parameter int ECAP = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] burst_i,
  output logic          done_o,
  output logic [EW-1:0] exp_o,
  output logic [MW-1:0] man_o
);
  localparam int CW = $clog2(BW);

  logic [BW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic          busy_q;

  // bit position of the leading one once sh_q is normalised
  assign pos = CW'(BW - 1) - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      exp_o  <= '0;
      man_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        if (burst_i == '0) begin
          exp_o  <= '0;
          man_o  <= '0;
          done_o <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          sh_q   <= burst_i;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (sh_q[BW-1]) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          if (pos > CW'(ECAP)) begin
            exp_o <= EW'(ECAP);
            man_o <= '1;
          end else begin
            exp_o <= EW'(pos);
            man_o <= (pos < CW'(MW)) ? '0 : sh_q[BW-2 -: MW];
          end
        end else begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_small_man_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (exp_o < EW'(MW))) |-> (man_o == '0));

  p_exp_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (exp_o <= EW'(ECAP)));
endmodule

// File: rtl/rate_norm.sv
module rate_norm #(
  parameter int RW   = 56,
  parameter int EW   = 5,
  parameter int DVW  = 5,
  parameter int ECAP = 22,
  localparam int NW  = RW - 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [RW-1:0]  rate_i,
  output logic           done_o,
  output logic [EW-1:0]  exp_o,
  output logic [DVW-1:0] rdiv_o,
  output logic [NW-1:0]  val_o,
  output logic           zero_o,
  output logic           sat_o
);
  import rbenc_pkg::*;

  localparam logic [NW-1:0] LO_N = NW'(WIN_LO);
  localparam logic [NW-1:0] HI_N = NW'(WIN_HI);

  logic [NW-1:0] scaled;
  logic          busy_q;

  assign scaled = NW'(rate_i >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o  <= '0;
      exp_o  <= '0;
      rdiv_o <= '0;
      zero_o <= 1'b0;
      sat_o  <= 1'b0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        val_o  <= scaled;
        exp_o  <= '0;
        rdiv_o <= '0;
        sat_o  <= 1'b0;
        if (scaled == '0) begin
          zero_o <= 1'b1;
          done_o <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          zero_o <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (val_o < LO_N) begin
          val_o  <= val_o << 1;
          rdiv_o <= rdiv_o + 1'b1;
        end else if ((val_o >= HI_N) && (exp_o < EW'(ECAP))) begin
          val_o <= val_o >> 1;
          exp_o <= exp_o + 1'b1;
        end else begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          sat_o  <= (val_o >= HI_N);
        end
      end
    end
  end

  p_win_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zero_o) |-> (val_o >= LO_N));

  p_win_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !zero_o && !sat_o) |-> (val_o < HI_N));

  p_sat_exp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sat_o) |-> ((exp_o == EW'(ECAP)) && (rdiv_o == '0)));
endmodule

// File: rtl/mant_div.sv
module mant_div #(
  parameter int          DW      = 28,
  parameter int          QW      = 8,
  parameter int unsigned DIVISOR = 1_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int CW = $clog2(QW);
  localparam logic [DW-1:0] DSR0 = DW'(DIVISOR * (32'd1 << (QW - 1)));

  logic [DW-1:0] rem_q;
  logic [DW-1:0] dsr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          ge;

  assign ge = (rem_q >= dsr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= dividend_i;
        dsr_q  <= DSR0;
        cnt_q  <= CW'(QW - 1);
        quo_o  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (ge) rem_q <= rem_q - dsr_q;
        quo_o <= {quo_o[QW-2:0], ge};
        dsr_q <= dsr_q >> 1;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // restoring invariant: partial remainder below twice the current divisor
  p_rem_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ({1'b0, rem_q} < {dsr_q, 1'b0}));
endmodule

// File: rtl/rate_burst_encoder.sv
module rate_burst_encoder #(
  parameter int BURST_W = 32,
  parameter int RATE_W  = 56
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic [RATE_W-1:0]  rate_i,
  output logic [4:0]         burst_exp_o,
  output logic [7:0]         burst_man_o,
  output logic [4:0]         rate_exp_o,
  output logic [7:0]         rate_man_o,
  output logic [4:0]         rate_div_o,
  output logic               done_o
);
  import rbenc_pkg::*;

  localparam int NW      = RATE_W - 2;
  localparam int DW      = $clog2(WIN_HI - WIN_LO);
  localparam int LAT_MAX = 48;
  localparam logic [NW-1:0] LO_N = NW'(WIN_LO);

  enc_state_e st_q;
  logic b_fin_q, r_fin_q, b_fin_n, r_fin_n;
  logic go;

  logic              bd_done;
  logic [EXP_W-1:0]  bd_exp;
  logic [MANT_W-1:0] bd_man;

  logic              rn_done, rn_zero, rn_sat;
  logic [EXP_W-1:0]  rn_exp;
  logic [RDIV_W-1:0] rn_div;
  logic [NW-1:0]     rn_val;

  logic              dv_start, dv_done;
  logic [DW-1:0]     dv_num;
  logic [MANT_W-1:0] dv_quo;

  logic [EXP_W-1:0]  sb_exp_q, sr_exp_q, nx_bexp, nx_rexp;
  logic [MANT_W-1:0] sb_man_q, sr_man_q, nx_bman, nx_rman;
  logic [RDIV_W-1:0] sr_div_q, nx_rdiv;
  logic [6:0]        lat_q;

  assign go       = (st_q == ST_IDLE) && start_i;
  assign dv_start = rn_done && !rn_zero && !rn_sat;
  assign dv_num   = DW'(rn_val - LO_N);
  assign b_fin_n  = b_fin_q | bd_done;
  assign r_fin_n  = r_fin_q | (rn_done & (rn_zero | rn_sat)) | dv_done;

  burst_enc #(.BW(BURST_W), .EW(EXP_W), .MW(MANT_W), .ECAP(EXP_CAP)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go), .burst_i(burst_i),
    .done_o(bd_done), .exp_o(bd_exp), .man_o(bd_man)
  );

  rate_norm #(.RW(RATE_W), .EW(EXP_W), .DVW(RDIV_W), .ECAP(EXP_CAP)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go), .rate_i(rate_i),
    .done_o(rn_done), .exp_o(rn_exp), .rdiv_o(rn_div), .val_o(rn_val),
    .zero_o(rn_zero), .sat_o(rn_sat)
  );

  mant_div #(.DW(DW), .QW(MANT_W), .DIVISOR(MANT_STEP)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dv_start), .dividend_i(dv_num),
    .done_o(dv_done), .quo_o(dv_quo)
  );

  always_comb begin
    nx_bexp = bd_done ? bd_exp : sb_exp_q;
    nx_bman = bd_done ? bd_man : sb_man_q;
    nx_rexp = rn_done ? rn_exp : sr_exp_q;
    nx_rdiv = rn_done ? rn_div : sr_div_q;
    if (dv_done)      nx_rman = dv_quo;
    else if (rn_done) nx_rman = rn_zero ? '0 : '1;
    else              nx_rman = sr_man_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      b_fin_q     <= 1'b0;
      r_fin_q     <= 1'b0;
      sb_exp_q    <= '0;
      sb_man_q    <= '0;
      sr_exp_q    <= '0;
      sr_man_q    <= '0;
      sr_div_q    <= '0;
      burst_exp_o <= '0;
      burst_man_o <= '0;
      rate_exp_o  <= '0;
      rate_man_o  <= '0;
      rate_div_o  <= '0;
      done_o      <= 1'b0;
      lat_q       <= '0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q    <= ST_NORM;
          b_fin_q <= 1'b0;
          r_fin_q <= 1'b0;
          lat_q   <= 7'd1;
        end
      end else begin
        lat_q    <= lat_q + 1'b1;
        sb_exp_q <= nx_bexp;
        sb_man_q <= nx_bman;
        sr_exp_q <= nx_rexp;
        sr_man_q <= nx_rman;
        sr_div_q <= nx_rdiv;
        b_fin_q  <= b_fin_n;
        r_fin_q  <= r_fin_n;
        if (dv_start) st_q <= ST_DIV;
        if (b_fin_n && r_fin_n) begin
          st_q        <= ST_IDLE;
          done_o      <= 1'b1;
          burst_exp_o <= nx_bexp;
          burst_man_o <= nx_bman;
          rate_exp_o  <= nx_rexp;
          rate_man_o  <= nx_rman;
          rate_div_o  <= nx_rdiv;
        end
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (lat_q <= 7'(LAT_MAX)));

  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ((st_q != ST_IDLE) || done_o));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({burst_exp_o, burst_man_o, rate_exp_o, rate_man_o, rate_div_o}));
endmodule

// File: tb/tb_rate_burst_encoder.sv
module tb_rate_burst_encoder;
  localparam int NV = 12;
  localparam logic [31:0] BV [NV] = '{
    32'd0, 32'd1, 32'd255, 32'd256, 32'd1000, 32'd65535,
    32'd8388607, 32'd8388608, 32'hFFFF_FFFF, 32'd300, 32'd1500000, 32'd7
  };
  localparam logic [55:0] RV [NV] = '{
    56'd0, 56'd4, 56'd1_000_000_000, 56'd1_200_000_000, 56'd2_047_999_999,
    56'd100_000_000_000, 56'd10_000, 56'd1, 56'hFF_FFFF_FFFF_FFFF, 56'd3,
    56'd25_000_000_000, 56'd8_600_000_000_000_000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] burst = '0;
  logic [55:0] rate = '0;
  logic [4:0]  bexp, rexp, rdiv;
  logic [7:0]  bman, rman;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  int lat;

  always #2 clk = ~clk;

  rate_burst_encoder dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .burst_i(burst), .rate_i(rate),
    .burst_exp_o(bexp), .burst_man_o(bman), .rate_exp_o(rexp), .rate_man_o(rman),
    .rate_div_o(rdiv), .done_o(done)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void mdl_burst(input longint unsigned b, output int e, output int m);
    int p = 0;
    e = 0; m = 0;
    if (b != 0) begin
      for (int i = 0; i < 32; i++) if (((b >> i) & 64'd1) != 0) p = i;
      if (p > 22) begin e = 22; m = 255; end
      else if (p < 8) begin e = p; m = 0; end
      else begin e = p; m = int'((b - (64'd1 << p)) >> (p - 8)); end
    end
  endfunction

  function automatic void mdl_rate(input longint unsigned r, output int e, output int m, output int d);
    longint unsigned s = r >> 2;
    e = 0; m = 0; d = 0;
    if (s != 0) begin
      while (s < 64'd256_000_000) begin s = s << 1; d++; end
      while (s >= 64'd512_000_000 && e < 22) begin s = s >> 1; e++; end
      if (s >= 64'd512_000_000) m = 255;
      else m = int'((s - 64'd256_000_000) / 64'd1_000_000);
    end
  endfunction

  // drive start for one cycle, return cycles until done seen (100 = timeout)
  task automatic run(input logic [31:0] b, input logic [55:0] r, output int cyc);
    @(negedge clk);
    burst = b; rate = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int eb, mb, er, mr, dr;
    logic [4:0] h_be, h_re, h_rd;
    logic [7:0] h_bm, h_rm;
    repeat (3) @(negedge clk);
    // reset state
    chk("R12 reset outputs", {bexp, bman, rexp, rman, rdiv}, 0);
    chk("R12 reset done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      mdl_burst(BV[v], eb, mb);
      mdl_rate(RV[v], er, mr, dr);
      run(BV[v], RV[v], lat);
      chk("R10 done within 48", (lat <= 48) ? 1 : 0, 1);
      chk(BV[v] == 0 ? "R9 burst exp" : (BV[v] >= 32'd8388608 ? "R3 burst exp" : "R1 burst exp"), bexp, eb);
      chk(BV[v] == 0 ? "R9 burst man" : (BV[v] >= 32'd8388608 ? "R3 burst man" : "R2 burst man"), bman, mb);
      chk((RV[v] >> 2) == 0 ? "R4 rate exp" : (er == 22 ? "R8 rate exp" : "R6 rate exp"), rexp, er);
      chk((RV[v] >> 2) == 0 ? "R4 rate div" : "R5 rate div", rdiv, dr);
      chk(mr == 255 && er == 22 ? "R8 rate man" : "R7 rate man", rman, mr);
      @(negedge clk);
      chk("R10 done one cycle", done, 0);
    end

    // R11: start ignored while busy
    mdl_burst(32'd1, eb, mb);
    mdl_rate(56'd4, er, mr, dr);
    @(negedge clk);
    burst = 32'd1; rate = 56'd4; start = 1'b1;
    @(negedge clk);
    burst = 32'd1000; rate = 56'd100_000_000_000;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R11 burst exp kept", bexp, eb);
    chk("R11 rate div kept", rdiv, dr);
    chk("R11 rate man kept", rman, mr);
    @(negedge clk);
    chk("R11 no second done", done, 0);

    // R12: outputs hold after done while inputs move
    h_be = bexp; h_bm = bman; h_re = rexp; h_rm = rman; h_rd = rdiv;
    burst = 32'd77777; rate = 56'd123_456_789;
    repeat (10) @(negedge clk);
    chk("R12 hold", {bexp, bman, rexp, rman, rdiv}, {h_be, h_bm, h_re, h_rm, h_rd});
    chk("R12 no spurious done", done, 0);

    // R6 corner: top of window boundary exactly 512e6 scaled
    mdl_rate(56'd2_048_000_000, er, mr, dr);
    run(32'd512, 56'd2_048_000_000, lat);
    chk("R6 window top exp", rexp, er);
    chk("R6 window top man", rman, mr);
    chk("R2 burst 512 man", bman, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule